// File: doc/BRIEF.md
# Secondary Hardware Thread Run-State Controller

This block holds the run state of the second hardware thread of a two-thread core and derives from it whether the core operates in simultaneous multithreading (SMT) mode or in single-thread mode. The thread is always in one of three states: Null, Dormant or Active. Software commands can place the thread in any of these states. A Dormant thread is also woken by hardware, through an external interrupt, a decrementer interrupt or a wake instruction executed by the running thread. A Null thread leaves Null only under software control.

The mode output tells shared-resource logic (queues, rename pools, fetch bandwidth) to give every resource to the running thread whenever the second thread is not Active. Each processor instance has its own controller, so the mode is decided per processor. Interrupt delivery and saving of architected state are handled elsewhere.

Top module: `thr_state_ctrl`

## Requirements
- R1: The state output uses the encoding 2'b00 Null, 2'b01 Dormant, 2'b10 Active. It is Null after reset and never shows 2'b11.
- R2: `smt_mode_o` is low after reset. It is high in the cycle after the first cycle in which the state is Active, and it is low in the cycle after the first cycle in which the state is not Active.
- R3: When `sw_req_i` is high and `sw_target_i` is 2'b00, 2'b01 or 2'b10, the state takes that value at the next clock edge, whatever the current state is. A target of 2'b11 is ignored and the state is unchanged.
- R4: The state becomes Dormant only through a software request with target 2'b01.
- R5: In Dormant, a high `ext_irq_i`, `dec_irq_i` or `wake_instr_i` makes the state Active at the next clock edge.
- R6: In Null, the three hardware wake inputs have no effect. The state stays Null unless software requests another state.
- R7: In Active, the three hardware wake inputs have no effect on the state.
- R8: In Dormant, when a hardware wake event and a software request occur in the same cycle, the wake event wins and the next state is Active, for any request target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | 1 | Software state-change request valid |
| sw_target_i | input | 2 | Requested state (00 Null, 01 Dormant, 10 Active) |
| ext_irq_i | input | 1 | External interrupt pending |
| dec_irq_i | input | 1 | Decrementer interrupt pending |
| wake_instr_i | input | 1 | Wake instruction issued by the running thread |
| state_o | output | 2 | Current thread state |
| smt_mode_o | output | 1 | High: resources shared by two threads; low: single-thread mode |

## Verification
A software request and a hardware wake event can occur in the same cycle, and the bench causes this on purpose. From each of the three starting states it applies every combination of request valid, request target and the three wake inputs for one cycle. It checks the next state against the wake-over-software rule for Dormant and the software-only rule for Null and Active. It also checks that the mode output follows the state one cycle later, both before and after the change.

// File: rtl/thr_state_pkg.sv
package thr_state_pkg;
   localparam int unsigned STATE_W = 2;
   typedef enum logic [STATE_W-1:0] {
      TS_NULL    = 2'b00,
      TS_DORMANT = 2'b01,
      TS_ACTIVE  = 2'b10,
      TS_ILLEGAL = 2'b11
   } thr_state_e;
endpackage

// File: rtl/thr_wake_merge.sv
module thr_wake_merge #(
   parameter int unsigned        NSRC   = 3,
   parameter logic [NSRC-1:0]    SRC_EN = '1
) (
   input  logic [NSRC-1:0] src_i,
   output logic            any_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("thr_wake_merge: NSRC must be at least 1");
   end

   logic [NSRC-1:0] gated;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (SRC_EN[i]) begin : g_on
         assign gated[i] = src_i[i];
      end else begin : g_off
         assign gated[i] = 1'b0;
      end
   end

   assign any_o = |gated;
endmodule

// File: rtl/thr_state_fsm.sv
module thr_state_fsm
   import thr_state_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_req_i,
   input  logic [STATE_W-1:0] sw_target_i,
   input  logic               wake_i,
   output logic [STATE_W-1:0] state_o
);
   thr_state_e cur_q, nxt;
   logic       sw_ok;

   assign sw_ok = sw_req_i && (sw_target_i != TS_ILLEGAL);

   always_comb begin
      nxt = cur_q;
      unique case (cur_q)
         TS_DORMANT: begin
            if (wake_i)      nxt = TS_ACTIVE;
            else if (sw_ok)  nxt = thr_state_e'(sw_target_i);
         end
         TS_NULL, TS_ACTIVE: begin
            if (sw_ok)       nxt = thr_state_e'(sw_target_i);
         end
         default:            nxt = TS_NULL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= TS_NULL;
      else        cur_q <= nxt;
   end

   assign state_o = cur_q;

   p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != TS_ILLEGAL);

   p_dormant_by_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != TS_DORMANT && !(sw_req_i && sw_target_i == TS_DORMANT))
      |=> state_o != TS_DORMANT);

   p_wake_dormant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == TS_DORMANT && wake_i) |=> state_o == TS_ACTIVE);

   p_null_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == TS_NULL && !sw_req_i) |=> state_o == TS_NULL);

   p_active_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == TS_ACTIVE && !sw_req_i) |=> state_o == TS_ACTIVE);

   p_sw_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req_i && sw_target_i != TS_ILLEGAL && !(state_o == TS_DORMANT && wake_i))
      |=> state_o == $past(sw_target_i));
endmodule

// File: rtl/thr_mode_reg.sv
module thr_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic smt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smt_o <= 1'b0;
      else        smt_o <= active_i;
   end

   p_mode_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      smt_o == $past(active_i));
endmodule

// File: rtl/thr_state_ctrl.sv
module thr_state_ctrl
   import thr_state_pkg::*;
#(
   parameter logic [2:0] WAKE_EN = 3'b111
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_req_i,
   input  logic [1:0] sw_target_i,
   input  logic       ext_irq_i,
   input  logic       dec_irq_i,
   input  logic       wake_instr_i,
   output logic [1:0] state_o,
   output logic       smt_mode_o
);
   localparam int unsigned NWAKE = 3;

   if (STATE_W != 2) begin : g_bad_w
      $error("thr_state_ctrl: state width must be 2");
   end

   logic wake_any;

   thr_wake_merge #(.NSRC(NWAKE), .SRC_EN(WAKE_EN)) u_wake (
      .src_i ({wake_instr_i, dec_irq_i, ext_irq_i}),
      .any_o (wake_any)
   );

   thr_state_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_req_i    (sw_req_i),
      .sw_target_i (sw_target_i),
      .wake_i      (wake_any),
      .state_o     (state_o)
   );

   thr_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (state_o == TS_ACTIVE),
      .smt_o    (smt_mode_o)
   );

   p_wake_beats_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == TS_DORMANT && sw_req_i && (ext_irq_i || dec_irq_i || wake_instr_i))
      |=> state_o == TS_ACTIVE);
endmodule

// File: tb/thr_state_ctrl_test.sv
module thr_state_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_req = 1'b0;
   logic [1:0] sw_tgt = 2'b00;
   logic       ext = 1'b0, dec = 1'b0, wk = 1'b0;
   logic [1:0] state;
   logic       smt;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thr_state_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .sw_target_i(sw_tgt),
      .ext_irq_i(ext), .dec_irq_i(dec), .wake_instr_i(wk),
      .state_o(state), .smt_mode_o(smt)
   );

   function automatic logic [1:0] model(logic [1:0] s, logic v, logic [1:0] t,
                                        logic e, logic d, logic w);
      if (s == 2'b01 && (e || d || w)) return 2'b10;
      if (v && t != 2'b11)             return t;
      return s;
   endfunction

   task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle();
      sw_req = 1'b0; sw_tgt = 2'b00; ext = 1'b0; dec = 1'b0; wk = 1'b0;
   endtask

   task automatic go_state(logic [1:0] s);
      @(negedge clk); sw_req = 1'b1; sw_tgt = s;
      @(negedge clk); idle();
      @(negedge clk);
   endtask

   initial begin
      idle();
      #(CLK_PERIOD*2 + 1);
      chk("R1 reset state", state, 2'b00);
      chk("R2 reset mode", {1'b0, smt}, 2'b00);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 state after reset", state, 2'b00);
      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < 64; c++) begin
            logic [1:0] st, tg, ex;
            logic v, e, d, w;
            string tag;
            st = 2'(s);
            {v, tg, e, d, w} = 6'(c);
            go_state(st);
            chk("R3 setup", state, st);
            ex = model(st, v, tg, e, d, w);
            if (st == 2'b01 && (e || d || w)) tag = v ? "R8 wake over sw" : "R5 wake";
            else if (v && tg == 2'b01)        tag = "R4 sw to dormant";
            else if (v)                       tag = "R3 sw request";
            else if (st == 2'b00)             tag = "R6 null ignores hw";
            else if (st == 2'b10)             tag = "R7 active ignores hw";
            else                              tag = "R4 dormant holds";
            @(negedge clk);
            sw_req = v; sw_tgt = tg; ext = e; dec = d; wk = w;
            @(negedge clk); idle();
            chk(tag, state, ex);
            chk("R1 no illegal code", {1'b0, state == 2'b11}, 2'b00);
            chk("R2 mode lags state", {1'b0, smt}, {1'b0, st == 2'b10});
            @(negedge clk);
            chk("R2 mode follows state", {1'b0, smt}, {1'b0, ex == 2'b10});
            chk("R3 state holds idle", state, ex);
         end
      end
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule